// File: doc/BRIEF.md
# Column Command Spacing Enforcer

This block sits between a memory controller's column command queue and the column packet output of a packetized DRAM channel. It takes one column command at a time on a valid/ready handshake. Each command has an opcode, a device, a bank and a column field. The block issues each command as soon as the spacing it needs after earlier packets has passed. A read that would follow buffered writes to its own device too closely is held back. In that case the block first puts a filler no-operation packet on the output so that the pending write is retired.

The spacing for a new command is chosen from the last issued packet and the new command. For a write followed by a read, the packet issued before that write also counts. The block also tracks whether a write is still unretired and which device it went to. All timing values are parameters counted in clock cycles. An issued packet appears on the output one cycle after it is accepted, and stays there for one cycle.

Top module: `colpkt_spacer`

## Requirements
- R1: After synchronous reset, out_valid is low and the history holds only no-operation packets with no write pending. The first command is accepted at once.
- R2: The opcode input is coded as 0 no-op, 1 read, 2 write, 3 precharge, 4 read-with-precharge and 5 write-with-precharge. An accepted command appears on the outputs one cycle after acceptance, for one cycle, with all four fields unchanged and out_filler low.
- R3: Any two output packets, fillers included, are at least T_CC cycles apart.
- R4: A read-type packet followed by a write-type command needs a spacing of T_CC + T_CAC − T_CWD cycles.
- R5: If either packet of a pair is a no-op type, the pair needs T_CC cycles. Read then read also needs T_CC, and so does write then write.
- R6: For write, write, read with all three on one device, the read issues max(T_RTR, 2·T_CC) cycles after the second write. A filler packet (opcode 0, out_filler high) is issued between them.
- R7: A write followed by a read needs only T_CC, with no filler, when the two target different devices. The same holds when the packet before the write was a no-op type, or was a write to another device.
- R8: For read, write, read on one device, the R6 spacing and filler apply only if a write to that device was unretired when the first read issued. Otherwise T_CC applies.
- R9: A write-type packet marks its device as holding an unretired write. A no-op-type packet or a filler clears that mark.
- R10: Precharge is spaced as a no-op, write-with-precharge as a write, and read-with-precharge as a read. Codes 6 and 7 are also spaced as no-ops.
- R11: in_ready stays low while the current command must wait. A filler is issued only while a read that needs it is waiting with in_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command present |
| in_ready | output | 1 | Command accepted this cycle when valid |
| in_op | input | 3 | Command opcode (R2 coding) |
| in_dev | input | DEV_W | Target device |
| in_bank | input | BANK_W | Target bank |
| in_col | input | COL_W | Target column |
| out_valid | output | 1 | Packet issued this cycle |
| out_filler | output | 1 | Issued packet is an inserted filler |
| out_op | output | 3 | Issued opcode |
| out_dev | output | DEV_W | Issued device |
| out_bank | output | BANK_W | Issued bank |
| out_col | output | COL_W | Issued column |

## Verification
The bench builds the block with T_CC=2, T_CAC=7, T_CWD=3 and T_RTR=5. With these values every spacing rule gives a different count: 2 for the base spacing, 6 for the read-to-write turnaround and 5 for the retire gap. The retire gap only just clears twice T_CC, so a filler squeezed into it must keep both of its neighbours T_CC away. Each three-packet case is run at these values, and so is a read that arrives late after two writes, where the filler has to use the slot the read was waiting for.

// File: rtl/colpkt_pkg.sv
package colpkt_pkg;

    // Opcode coding on the command and packet ports
    localparam logic [2:0] OP_NOCOP = 3'd0;
    localparam logic [2:0] OP_RD    = 3'd1;
    localparam logic [2:0] OP_WR    = 3'd2;
    localparam logic [2:0] OP_PREC  = 3'd3;
    localparam logic [2:0] OP_RDA   = 3'd4;
    localparam logic [2:0] OP_WRA   = 3'd5;

    // Spacing class of a packet
    typedef enum logic [1:0] {
        K_IDLE  = 2'd0,
        K_READ  = 2'd1,
        K_WRITE = 2'd2
    } kind_e;

    // Which spacing rule applies to the waiting command
    typedef enum logic [1:0] {
        GAP_BASE   = 2'd0,
        GAP_TURN   = 2'd1,
        GAP_RETIRE = 2'd2
    } gap_sel_e;

    function automatic kind_e op_kind(input logic [2:0] op);
        kind_e k;
        case (op)
            OP_RD, OP_RDA: k = K_READ;
            OP_WR, OP_WRA: k = K_WRITE;
            default:       k = K_IDLE;
        endcase
        return k;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cnt_width(input int maxval);
        int w;
        w = 1;
        while ((1 << w) <= maxval) w++;
        return w;
    endfunction

endpackage

// File: rtl/colpkt_hist.sv
module colpkt_hist
    import colpkt_pkg::*;
#(
    parameter int DEV_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue,
    input  logic             fill,
    input  kind_e            c_kind,
    input  logic [DEV_W-1:0] c_dev,
    output kind_e            a_kind,
    output logic [DEV_W-1:0] a_dev,
    output logic             a_pend,
    output kind_e            b_kind,
    output logic [DEV_W-1:0] b_dev
);

    logic             b_pend;
    logic             unret_vld;
    logic [DEV_W-1:0] unret_dev;
    logic             c_hits_unret;

    assign c_hits_unret = unret_vld && (unret_dev == c_dev);

    always_ff @(posedge clk) begin
        if (rst) begin
            a_kind    <= K_IDLE;
            a_dev     <= '0;
            a_pend    <= 1'b0;
            b_kind    <= K_IDLE;
            b_dev     <= '0;
            b_pend    <= 1'b0;
            unret_vld <= 1'b0;
            unret_dev <= '0;
        end else if (issue) begin
            a_kind <= b_kind;
            a_dev  <= b_dev;
            a_pend <= b_pend;
            b_kind <= c_kind;
            b_dev  <= c_dev;
            b_pend <= c_hits_unret;
            if (c_kind == K_WRITE) begin
                unret_vld <= 1'b1;
                unret_dev <= c_dev;
            end else if (c_kind == K_IDLE) begin
                unret_vld <= 1'b0;
            end
        end else if (fill) begin
            unret_vld <= 1'b0;
        end
    end

    // R9
    wr_marks_dev_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && c_kind == K_WRITE) |=> (unret_vld && unret_dev == $past(c_dev)));

    // R9
    fill_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (fill && !issue) |=> !unret_vld);

endmodule

// File: rtl/colpkt_rules.sv
module colpkt_rules
    import colpkt_pkg::*;
#(
    parameter int DEV_W = 5
) (
    input  kind_e            a_kind,
    input  logic [DEV_W-1:0] a_dev,
    input  logic             a_pend,
    input  kind_e            b_kind,
    input  logic [DEV_W-1:0] b_dev,
    input  kind_e            c_kind,
    input  logic [DEV_W-1:0] c_dev,
    output logic             hazard,
    output gap_sel_e         gap_sel
);

    logic wr_then_rd_same;
    logic a_holds_write;

    assign wr_then_rd_same = (b_kind == K_WRITE) && (c_kind == K_READ) && (c_dev == b_dev);
    assign a_holds_write   = (a_dev == b_dev) &&
                             ((a_kind == K_WRITE) || ((a_kind == K_READ) && a_pend));
    assign hazard          = wr_then_rd_same && a_holds_write;

    always_comb begin
        if (b_kind == K_IDLE || c_kind == K_IDLE)
            gap_sel = GAP_BASE;
        else if (hazard)
            gap_sel = GAP_RETIRE;
        else if (b_kind == K_READ && c_kind == K_WRITE)
            gap_sel = GAP_TURN;
        else
            gap_sel = GAP_BASE;
    end

endmodule

// File: rtl/colpkt_timer.sv
module colpkt_timer
    import colpkt_pkg::*;
#(
    parameter int T_CC  = 4,
    parameter int T_CAC = 8,
    parameter int T_CWD = 6,
    parameter int T_RTR = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     issue,
    input  logic     fill,
    input  gap_sel_e gap_sel,
    output logic     gap_ok,
    output logic     any_ok
);

    localparam int TURN    = T_CC + T_CAC - T_CWD;
    localparam int RTR_EFF = imax(T_RTR, 2 * T_CC);
    localparam int MAXG    = imax(TURN, RTR_EFF);
    localparam int CW      = cnt_width(MAXG);

    localparam logic [CW-1:0] C_MAX  = CW'(MAXG);
    localparam logic [CW-1:0] C_ONE  = CW'(1);
    localparam logic [CW-1:0] C_CC   = CW'(T_CC);
    localparam logic [CW-1:0] C_TURN = CW'(TURN);
    localparam logic [CW-1:0] C_RTR  = CW'(RTR_EFF);

    logic [CW-1:0] since_real;
    logic [CW-1:0] since_any;
    logic [CW-1:0] need;

    always_comb begin
        case (gap_sel)
            GAP_TURN:   need = C_TURN;
            GAP_RETIRE: need = C_RTR;
            default:    need = C_CC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            since_real <= C_MAX;
            since_any  <= C_MAX;
        end else begin
            if (issue)
                since_real <= C_ONE;
            else if (since_real != C_MAX)
                since_real <= since_real + C_ONE;
            if (issue || fill)
                since_any <= C_ONE;
            else if (since_any != C_MAX)
                since_any <= since_any + C_ONE;
        end
    end

    assign gap_ok = (since_real >= need);
    assign any_ok = (since_any >= C_CC);

    // R6
    retire_window_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && gap_sel == GAP_RETIRE) |-> (since_real >= C_RTR));

endmodule

// File: rtl/colpkt_spacer.sv
module colpkt_spacer
    import colpkt_pkg::*;
#(
    parameter int DEV_W  = 5,
    parameter int BANK_W = 4,
    parameter int COL_W  = 6,
    parameter int T_CC   = 4,
    parameter int T_CAC  = 8,
    parameter int T_CWD  = 6,
    parameter int T_RTR  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_op,
    input  logic [DEV_W-1:0]  in_dev,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [COL_W-1:0]  in_col,
    output logic              out_valid,
    output logic              out_filler,
    output logic [2:0]        out_op,
    output logic [DEV_W-1:0]  out_dev,
    output logic [BANK_W-1:0] out_bank,
    output logic [COL_W-1:0]  out_col
);

    localparam int SW = cnt_width(T_CC);

    kind_e            c_kind;
    kind_e            a_kind, b_kind;
    logic [DEV_W-1:0] a_dev, b_dev;
    logic             a_pend;
    logic             hazard;
    gap_sel_e         gap_sel;
    logic             gap_ok, any_ok;
    logic             fill_done;
    logic             fill_fire;
    logic             take;

    assign c_kind = op_kind(in_op);

    colpkt_hist #(.DEV_W(DEV_W)) u_hist (
        .clk    (clk),
        .rst    (rst),
        .issue  (take),
        .fill   (fill_fire),
        .c_kind (c_kind),
        .c_dev  (in_dev),
        .a_kind (a_kind),
        .a_dev  (a_dev),
        .a_pend (a_pend),
        .b_kind (b_kind),
        .b_dev  (b_dev)
    );

    colpkt_rules #(.DEV_W(DEV_W)) u_rules (
        .a_kind  (a_kind),
        .a_dev   (a_dev),
        .a_pend  (a_pend),
        .b_kind  (b_kind),
        .b_dev   (b_dev),
        .c_kind  (c_kind),
        .c_dev   (in_dev),
        .hazard  (hazard),
        .gap_sel (gap_sel)
    );

    colpkt_timer #(
        .T_CC  (T_CC),
        .T_CAC (T_CAC),
        .T_CWD (T_CWD),
        .T_RTR (T_RTR)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .issue   (take),
        .fill    (fill_fire),
        .gap_sel (gap_sel),
        .gap_ok  (gap_ok),
        .any_ok  (any_ok)
    );

    assign in_ready  = gap_ok && any_ok && !(hazard && !fill_done);
    assign take      = in_valid && in_ready;
    assign fill_fire = in_valid && hazard && !fill_done && any_ok;

    always_ff @(posedge clk) begin
        if (rst)
            fill_done <= 1'b0;
        else if (take)
            fill_done <= 1'b0;
        else if (fill_fire)
            fill_done <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_filler <= 1'b0;
            out_op     <= OP_NOCOP;
            out_dev    <= '0;
            out_bank   <= '0;
            out_col    <= '0;
        end else begin
            out_valid  <= take || fill_fire;
            out_filler <= fill_fire;
            if (take) begin
                out_op   <= in_op;
                out_dev  <= in_dev;
                out_bank <= in_bank;
                out_col  <= in_col;
            end else begin
                out_op   <= OP_NOCOP;
                out_dev  <= '0;
                out_bank <= '0;
                out_col  <= '0;
            end
        end
    end

    // Spacing monitor feeding the output spacing check
    logic [SW-1:0] out_gap;
    always_ff @(posedge clk) begin
        if (rst)
            out_gap <= SW'(T_CC);
        else if (out_valid)
            out_gap <= SW'(1);
        else if (out_gap != SW'(T_CC))
            out_gap <= out_gap + SW'(1);
    end

    // R3
    out_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_gap >= SW'(T_CC)));

    // R2
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (out_valid && !out_filler && out_op == $past(in_op) &&
                  out_dev == $past(in_dev) && out_bank == $past(in_bank) &&
                  out_col == $past(in_col)));

    // R6
    filler_is_noop_chk: assert property (@(posedge clk) disable iff (rst)
        out_filler |-> (out_valid && out_op == OP_NOCOP));

    // R11
    filler_stalls_chk: assert property (@(posedge clk) disable iff (rst)
        fill_fire |-> (!in_ready && in_valid));

endmodule

// File: tb/sim_colpkt_spacer.sv
module sim_colpkt_spacer;

    localparam int CLK_P  = 10;
    localparam int DEV_W  = 5;
    localparam int BANK_W = 4;
    localparam int COL_W  = 6;
    localparam int TCC    = 2;
    localparam int TCAC   = 7;
    localparam int TCWD   = 3;
    localparam int TRTR   = 5;
    localparam int RTR_E  = (TRTR > 2 * TCC) ? TRTR : 2 * TCC;
    localparam int TURN   = TCC + TCAC - TCWD;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [2:0]        in_op = 3'd0;
    logic [DEV_W-1:0]  in_dev = '0;
    logic [BANK_W-1:0] in_bank = '0;
    logic [COL_W-1:0]  in_col = '0;
    logic              out_valid, out_filler;
    logic [2:0]        out_op;
    logic [DEV_W-1:0]  out_dev;
    logic [BANK_W-1:0] out_bank;
    logic [COL_W-1:0]  out_col;

    always #(CLK_P / 2) clk = ~clk;

    colpkt_spacer #(
        .DEV_W(DEV_W), .BANK_W(BANK_W), .COL_W(COL_W),
        .T_CC(TCC), .T_CAC(TCAC), .T_CWD(TCWD), .T_RTR(TRTR)
    ) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_dev(in_dev), .in_bank(in_bank), .in_col(in_col),
        .out_valid(out_valid), .out_filler(out_filler), .out_op(out_op),
        .out_dev(out_dev), .out_bank(out_bank), .out_col(out_col)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;
    string cur_req = "R1";

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int kind_of(input int op);
        if (op == 1 || op == 4) return 1;
        if (op == 2 || op == 5) return 2;
        return 0;
    endfunction

    // Behavioural reference: absolute cycle numbers and a three-deep history
    int now = 0;
    int last_real = -1000, last_any = -1000;
    int ha_k = 0, ha_d = 0, ha_p = 0, hb_k = 0, hb_d = 0, hb_p = 0;
    int un_v = 0, un_d = 0, fdone = 0;
    int e_v = 0, e_f = 0, e_op = 0, e_dev = 0, e_bank = 0, e_col = 0;
    // Observations for scenario checks
    int lst_t = 0, prv_t = 0, fill_t = 0, fill_cnt = 0;

    always @(negedge clk) begin
        if (rst) begin
            now = 0; last_real = -1000; last_any = -1000;
            ha_k = 0; ha_d = 0; ha_p = 0; hb_k = 0; hb_d = 0; hb_p = 0;
            un_v = 0; un_d = 0; fdone = 0; e_v = 0; e_f = 0;
        end else begin
            int k, haz, need, rdy, fl, acc, dv;
            now++;
            check(cur_req, "out_valid", int'(out_valid), e_v);
            if (e_v != 0) begin
                check(cur_req, "out_filler", int'(out_filler), e_f);
                check(cur_req, "out_op", int'(out_op), e_op);
                if (e_f == 0) begin
                    check(cur_req, "out_dev", int'(out_dev), e_dev);
                    check(cur_req, "out_bank", int'(out_bank), e_bank);
                    check(cur_req, "out_col", int'(out_col), e_col);
                end
            end
            if (out_valid && !out_filler) begin prv_t = lst_t; lst_t = now; end
            if (out_valid && out_filler) begin fill_t = now; fill_cnt++; end

            k  = kind_of(int'(in_op));
            dv = int'(in_dev);
            haz = (hb_k == 2 && k == 1 && dv == hb_d && ha_d == hb_d &&
                   (ha_k == 2 || (ha_k == 1 && ha_p != 0))) ? 1 : 0;
            if (hb_k == 0 || k == 0) need = TCC;
            else if (haz != 0)       need = RTR_E;
            else if (hb_k == 1 && k == 2) need = TURN;
            else                     need = TCC;
            rdy = ((now - last_any) >= TCC && (now - last_real) >= need &&
                   !(haz != 0 && fdone == 0)) ? 1 : 0;
            check(cur_req, "in_ready", int'(in_ready), rdy);
            fl  = (in_valid && haz != 0 && fdone == 0 && (now - last_any) >= TCC) ? 1 : 0;
            acc = (in_valid && rdy != 0) ? 1 : 0;
            e_v = 0; e_f = 0;
            if (acc != 0) begin
                e_v = 1; e_op = int'(in_op); e_dev = dv;
                e_bank = int'(in_bank); e_col = int'(in_col);
                ha_k = hb_k; ha_d = hb_d; ha_p = hb_p;
                hb_k = k; hb_d = dv; hb_p = (un_v != 0 && un_d == dv) ? 1 : 0;
                if (k == 2) begin un_v = 1; un_d = dv; end
                else if (k == 0) un_v = 0;
                last_real = now; last_any = now; fdone = 0;
            end else if (fl != 0) begin
                e_v = 1; e_f = 1; e_op = 0;
                un_v = 0; last_any = now; fdone = 1;
            end
        end
    end

    task automatic send(input int op, input int dev, input int bank, input int col);
        in_valid = 1'b1;
        in_op    = op[2:0];
        in_dev   = dev[DEV_W-1:0];
        in_bank  = bank[BANK_W-1:0];
        in_col   = col[COL_W-1:0];
        forever begin
            bit r;
            @(negedge clk);
            r = in_ready;
            @(posedge clk);
            #1;
            if (r) break;
        end
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic gap_is(input string req, input int exp);
        idle(3);
        check(req, "issue spacing", lst_t - prv_t, exp);
    endtask

    initial begin
        int f0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state, ready for the first command
        check("R1", "out_valid after reset", int'(out_valid), 0);
        check("R1", "in_ready after reset", int'(in_ready), 1);
        @(posedge clk); #1;

        cur_req = "R2";
        send(1, 3, 9, 41);
        idle(3);

        cur_req = "R5";  // read then read
        send(0, 0, 0, 0); send(1, 1, 2, 3); send(1, 1, 4, 5);
        gap_is("R5", TCC);

        cur_req = "R4";  // read then write
        send(0, 0, 0, 0); send(1, 1, 1, 1); send(2, 1, 2, 2);
        gap_is("R4", TURN);

        cur_req = "R6";  // write, write, read on one device
        f0 = fill_cnt;
        send(0, 0, 0, 0); send(2, 2, 1, 1); send(2, 2, 1, 2); send(1, 2, 3, 4);
        gap_is("R6", RTR_E);
        check("R6", "fillers inserted", fill_cnt - f0, 1);
        check("R3", "filler to read spacing", lst_t - fill_t, RTR_E - TCC);

        cur_req = "R7";  // earlier write went to another device
        f0 = fill_cnt;
        send(0, 0, 0, 0); send(2, 1, 0, 0); send(2, 2, 0, 1); send(1, 2, 0, 2);
        gap_is("R7", TCC);
        send(0, 0, 0, 0); send(2, 1, 0, 0); send(1, 2, 0, 1);
        gap_is("R7", TCC);
        send(2, 3, 0, 0); send(0, 0, 0, 0); send(2, 3, 0, 1); send(1, 3, 0, 2);
        gap_is("R7", TCC);
        check("R7", "no filler", fill_cnt - f0, 0);

        cur_req = "R8";  // read, write, read with pending write
        f0 = fill_cnt;
        send(0, 0, 0, 0); send(2, 4, 0, 0); send(1, 4, 0, 1); send(2, 4, 0, 2); send(1, 4, 0, 3);
        gap_is("R8", RTR_E);
        check("R8", "filler with pending write", fill_cnt - f0, 1);
        f0 = fill_cnt;
        send(0, 0, 0, 0); send(1, 4, 0, 0); send(2, 4, 0, 1); send(1, 4, 0, 2);
        gap_is("R8", TCC);
        check("R8", "no filler without pending write", fill_cnt - f0, 0);

        cur_req = "R9";  // precharge retires the write before the first read
        f0 = fill_cnt;
        send(0, 0, 0, 0); send(2, 7, 0, 0); send(3, 7, 0, 0); send(1, 7, 0, 1);
        send(2, 7, 0, 2); send(1, 7, 0, 3);
        gap_is("R9", TCC);
        check("R9", "no filler after precharge", fill_cnt - f0, 0);

        cur_req = "R10";  // auto-precharge aliases
        f0 = fill_cnt;
        send(3, 0, 0, 0); send(5, 5, 1, 0); send(5, 5, 1, 1); send(4, 5, 1, 2);
        gap_is("R10", RTR_E);
        check("R10", "filler for aliased ops", fill_cnt - f0, 1);
        send(3, 5, 0, 0); send(4, 5, 0, 0);
        gap_is("R10", TCC);
        send(6, 0, 0, 0); send(4, 5, 0, 0); send(5, 5, 0, 1);
        gap_is("R10", TURN);

        cur_req = "R11";  // read arrives late after two writes
        f0 = fill_cnt;
        send(0, 0, 0, 0); send(2, 6, 0, 0); send(2, 6, 0, 1);
        idle(10);
        check("R11", "no filler while idle", fill_cnt - f0, 0);
        send(1, 6, 0, 2);
        idle(3);
        check("R11", "filler once read waits", fill_cnt - f0, 1);
        check("R3", "late filler to read spacing", lst_t - fill_t, TCC);

        idle(5);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule